// File: doc/BRIEF.md
# Unmapped-Block Filter

Each core carries a small, fully associative store of cache-block addresses that a remote resolution has shown to be absent from every core's scratchpad. A guarded memory access first asks this filter. On a hit the access goes straight to the cache hierarchy and needs no remote lookup. On a miss the access takes the slow resolution path. When that path finds the block unmapped, it writes the block into the filter through the insert port.

The filter holds negative knowledge, so it must drop an entry as soon as any core maps the block. Remote requests do this through the invalidate port. When an insert lands in a full filter, a tree pseudo-LRU victim is replaced. The victim's block address is reported on the eviction port so that a central tracker of filter contents stays exact. Every port carries a block address: the byte offset has already been removed by the requester.

Top module: `nmf_filter`

## Requirements
- R1: After synchronous reset every entry is invalid, so every lookup misses and no eviction pulse is produced.
- R2: A lookup presented in cycle t is answered in cycle t+1: `lkp_resp_valid` is high and `lkp_hit` shows whether the block was held at cycle t.
- R3: A block that has been inserted, and not invalidated or evicted since, hits on lookup.
- R4: Inserting a block that is already held writes no second entry. It only refreshes that entry's replacement state.
- R5: Invalidating a held block makes later lookups of it miss. Invalidating a block that is not held leaves every other entry unchanged.
- R6: When invalidate and lookup name the same block in one cycle, the lookup reports a miss.
- R7: When invalidate and insert name the same block in one cycle, the block is not stored and no eviction occurs.
- R8: An insert uses an invalid entry when one exists, the lowest-numbered one first (entries freed by an invalidate in the same cycle count as free). No eviction pulse occurs while a free entry exists.
- R9: An insert of a new block into a full filter replaces the pseudo-LRU victim. One cycle later `evict_valid` pulses for one cycle and `evict_addr` carries the victim's block address. The tree has 2^ceil(log2 ENTRIES) leaves, and leaf i is entry i. Each node points toward the half that holds the victim, and a new access to a leaf turns every node on its path away from that leaf. A node whose pointed-to half holds no real entry goes the other way.
- R10: A lookup hit refreshes the hit entry's pseudo-LRU state in the same way an insert does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lkp_valid | input | 1 | Lookup request |
| lkp_addr | input | BLK_W | Block address to look up |
| lkp_resp_valid | output | 1 | Lookup answer valid (one cycle after request) |
| lkp_hit | output | 1 | Block found in filter |
| ins_valid | input | 1 | Insert request (block confirmed unmapped) |
| ins_addr | input | BLK_W | Block address to insert |
| inv_valid | input | 1 | Invalidate request (block became mapped) |
| inv_addr | input | BLK_W | Block address to drop |
| evict_valid | output | 1 | One-cycle pulse: an entry was replaced |
| evict_addr | output | BLK_W | Block address of the replaced entry |

## Verification
The bench fills all 48 entries with one insert repeated early. A design that stored the duplicate would need a 49th slot and would emit an eviction during the fill. It then walks three evictions whose victims follow from the tree rules: the first entry, then entry 32, then entry 40 after a lookup has refreshed entry 16. A design that mishandled the 48-of-64 leaf skip, or did not let lookups touch the tree, would report a different victim address. Same-cycle collisions of invalidate with lookup and with insert are driven explicitly. A design that let either win would answer a hit or keep a stale block. Invalidation of an absent block and re-use of a freed slot without an eviction pulse are also covered.

// File: rtl/nmf_pkg.sv
package nmf_pkg;
  // Leaf count of the replacement tree: entries rounded up to a power of two.
  function automatic int unsigned nmf_leaves(input int unsigned n);
    return 32'd1 << $clog2(n);
  endfunction
endpackage

// File: rtl/nmf_tag_array.sv
module nmf_tag_array #(
  parameter int ENTRIES = 48,
  parameter int BLK_W   = 26,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [BLK_W-1:0]   lkp_tag,
  input  logic [BLK_W-1:0]   ins_tag,
  input  logic [BLK_W-1:0]   inv_tag,
  output logic [ENTRIES-1:0] lkp_match,
  output logic [ENTRIES-1:0] ins_match,
  output logic [ENTRIES-1:0] inv_match,
  output logic [ENTRIES-1:0] valid_vec,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [BLK_W-1:0]   wr_tag,
  input  logic [ENTRIES-1:0] clr_vec,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [BLK_W-1:0]   rd_tag
);
  logic [BLK_W-1:0]   tag_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] wr_onehot;

  // Tag storage: single write port, no reset, so it maps to plain storage.
  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_idx] <= wr_tag;
  end

  always_comb begin
    wr_onehot = '0;
    if (wr_en) wr_onehot[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else     valid_q <= (valid_q & ~clr_vec) | wr_onehot;
  end

  // Parallel compare, one comparator set per entry.
  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign lkp_match[e] = valid_q[e] && (tag_q[e] == lkp_tag);
    assign ins_match[e] = valid_q[e] && (tag_q[e] == ins_tag);
    assign inv_match[e] = valid_q[e] && (tag_q[e] == inv_tag);
  end

  assign valid_vec = valid_q;
  assign rd_tag    = tag_q[rd_idx];

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (rst)
    $countones(lkp_match) <= 1); // R4
endmodule

// File: rtl/nmf_first_free.sv
module nmf_first_free #(
  parameter int ENTRIES = 48,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] avail,
  output logic               found,
  output logic [IDX_W-1:0]   idx
);
  // Scan from the top so the lowest free entry is the one left standing.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (avail[e]) begin
        found = 1'b1;
        idx   = IDX_W'(e);
      end
    end
  end
endmodule

// File: rtl/nmf_plru.sv
module nmf_plru #(
  parameter int ENTRIES = 48,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int LEAVES = nmf_pkg::nmf_leaves(ENTRIES),
  localparam int NODES  = LEAVES - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch_a_en,
  input  logic [IDX_W-1:0] touch_a_idx,
  input  logic             touch_b_en,
  input  logic [IDX_W-1:0] touch_b_idx,
  output logic [IDX_W-1:0] victim_idx
);
  logic [NODES-1:0] tree_q;
  logic [NODES-1:0] tree_a;
  logic [NODES-1:0] tree_b;

  // Node bit 1: victim lies in the upper half. Touching a leaf points every
  // node on its path to the opposite half.
  function automatic logic [NODES-1:0] touch_leaf(input logic [NODES-1:0] t,
                                                  input logic [IDX_W-1:0] leaf);
    int node;
    node = 0;
    for (int l = 0; l < IDX_W; l++) begin
      t[node] = ~leaf[IDX_W-1-l];
      node    = 2 * node + 1 + int'(leaf[IDX_W-1-l]);
    end
    return t;
  endfunction

  // Descend toward the victim; never enter a half with no real entries.
  function automatic logic [IDX_W-1:0] find_victim(input logic [NODES-1:0] t);
    int node;
    int prefix;
    int lo_upper;
    logic dir;
    node   = 0;
    prefix = 0;
    for (int l = 0; l < IDX_W; l++) begin
      dir      = t[node];
      lo_upper = (prefix * 2 + 1) << (IDX_W - 1 - l);
      if (lo_upper >= ENTRIES) dir = 1'b0;
      prefix = prefix * 2 + int'(dir);
      node   = 2 * node + 1 + int'(dir);
    end
    return IDX_W'(prefix);
  endfunction

  always_comb begin
    tree_a = touch_a_en ? touch_leaf(tree_q, touch_a_idx) : tree_q;
    tree_b = touch_b_en ? touch_leaf(tree_a, touch_b_idx) : tree_a;
  end

  always_ff @(posedge clk) begin
    if (rst) tree_q <= '0;
    else     tree_q <= tree_b;
  end

  assign victim_idx = find_victim(tree_q);

  AST_VICTIM_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    int'(victim_idx) < ENTRIES); // R9
endmodule

// File: rtl/nmf_filter.sv
module nmf_filter #(
  parameter int ENTRIES = 48,
  parameter int BLK_W   = 26,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lkp_valid,
  input  logic [BLK_W-1:0] lkp_addr,
  output logic             lkp_resp_valid,
  output logic             lkp_hit,
  input  logic             ins_valid,
  input  logic [BLK_W-1:0] ins_addr,
  input  logic             inv_valid,
  input  logic [BLK_W-1:0] inv_addr,
  output logic             evict_valid,
  output logic [BLK_W-1:0] evict_addr
);
  logic [ENTRIES-1:0] lkp_match, ins_match, inv_match, valid_vec;
  logic [ENTRIES-1:0] inv_vec, lkp_vec, avail;
  logic               lkp_any, ins_clash, ins_go, ins_present;
  logic               has_free, wr_en, do_evict;
  logic [IDX_W-1:0]   free_idx, victim_idx, wr_idx, lkp_idx, ins_idx, touch_b_idx;
  logic [BLK_W-1:0]   victim_tag;

  nmf_tag_array #(.ENTRIES(ENTRIES), .BLK_W(BLK_W)) tags_i (
    .clk(clk), .rst(rst),
    .lkp_tag(lkp_addr), .ins_tag(ins_addr), .inv_tag(inv_addr),
    .lkp_match(lkp_match), .ins_match(ins_match), .inv_match(inv_match),
    .valid_vec(valid_vec),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(ins_addr),
    .clr_vec(inv_vec), .rd_idx(victim_idx), .rd_tag(victim_tag)
  );

  // Invalidate takes precedence over both lookup and insert.
  assign inv_vec   = inv_valid ? inv_match : '0;
  assign lkp_vec   = lkp_valid ? (lkp_match & ~inv_vec) : '0;
  assign lkp_any   = |lkp_vec;
  assign ins_clash = inv_valid && (inv_addr == ins_addr);
  assign ins_go    = ins_valid && !ins_clash;
  assign ins_present = |ins_match;
  assign avail     = ~valid_vec | inv_vec;

  nmf_first_free #(.ENTRIES(ENTRIES)) free_i (
    .avail(avail), .found(has_free), .idx(free_idx)
  );

  always_comb begin
    lkp_idx = '0;
    ins_idx = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (lkp_vec[e])   lkp_idx = IDX_W'(e);
      if (ins_match[e]) ins_idx = IDX_W'(e);
    end
  end

  assign wr_en       = ins_go && !ins_present;
  assign wr_idx      = has_free ? free_idx : victim_idx;
  assign do_evict    = wr_en && !has_free;
  assign touch_b_idx = ins_present ? ins_idx : wr_idx;

  nmf_plru #(.ENTRIES(ENTRIES)) plru_i (
    .clk(clk), .rst(rst),
    .touch_a_en(lkp_any), .touch_a_idx(lkp_idx),
    .touch_b_en(ins_go), .touch_b_idx(touch_b_idx),
    .victim_idx(victim_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lkp_resp_valid <= 1'b0;
      lkp_hit        <= 1'b0;
      evict_valid    <= 1'b0;
      evict_addr     <= '0;
    end else begin
      lkp_resp_valid <= lkp_valid;
      lkp_hit        <= lkp_any;
      evict_valid    <= do_evict;
      if (do_evict) evict_addr <= victim_tag;
    end
  end

  AST_RESP_NEXT: assert property (@(posedge clk) disable iff (rst)
    lkp_valid |=> lkp_resp_valid); // R2
  AST_INV_BEATS_LKP: assert property (@(posedge clk) disable iff (rst)
    (lkp_valid && inv_valid && lkp_addr == inv_addr) |=> !lkp_hit); // R6
  AST_EVICT_NEEDS_INSERT: assert property (@(posedge clk) disable iff (rst)
    evict_valid |-> $past(ins_valid)); // R9
  AST_EVICT_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
    evict_valid |-> $past(&valid_vec)); // R8
  AST_CLASH_NO_EVICT: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && inv_valid && ins_addr == inv_addr) |=> !evict_valid); // R7
endmodule

// File: tb/nmf_filter_tb.sv
module nmf_filter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BLK_W = 26;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lkp_valid = 1'b0, ins_valid = 1'b0, inv_valid = 1'b0;
  logic [BLK_W-1:0] lkp_addr = '0, ins_addr = '0, inv_addr = '0;
  logic lkp_resp_valid, lkp_hit, evict_valid;
  logic [BLK_W-1:0] evict_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic             exp_hit_q [$];
  string            exp_hit_r [$];
  logic [BLK_W-1:0] exp_ev_q  [$];
  string            exp_ev_r  [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  nmf_filter #(.ENTRIES(48), .BLK_W(BLK_W)) dut_i (
    .clk(clk), .rst(rst),
    .lkp_valid(lkp_valid), .lkp_addr(lkp_addr),
    .lkp_resp_valid(lkp_resp_valid), .lkp_hit(lkp_hit),
    .ins_valid(ins_valid), .ins_addr(ins_addr),
    .inv_valid(inv_valid), .inv_addr(inv_addr),
    .evict_valid(evict_valid), .evict_addr(evict_addr)
  );

  function automatic logic [BLK_W-1:0] blk_b(input int k);
    return BLK_W'(32'h0010_0000 + k);
  endfunction
  function automatic logic [BLK_W-1:0] blk_n(input int k);
    return BLK_W'(32'h0020_0000 + k);
  endfunction

  // Monitor: compare results against the scoreboard queues.
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (lkp_resp_valid) begin
        checks++;
        if (exp_hit_q.size() == 0) begin
          fails++;
          $display("FAIL unexpected lookup response: actual hit=%0b expected none (R2)", lkp_hit);
        end else begin
          logic  e;
          string r;
          e = exp_hit_q.pop_front();
          r = exp_hit_r.pop_front();
          if (lkp_hit !== e) begin
            fails++;
            $display("FAIL %s lookup: actual hit=%0b expected %0b", r, lkp_hit, e);
          end
        end
      end
      if (evict_valid) begin
        checks++;
        if (exp_ev_q.size() == 0) begin
          fails++;
          $display("FAIL R8 unexpected eviction: actual addr=%h expected no pulse", evict_addr);
        end else begin
          logic [BLK_W-1:0] a;
          string r;
          a = exp_ev_q.pop_front();
          r = exp_ev_r.pop_front();
          if (evict_addr !== a) begin
            fails++;
            $display("FAIL %s eviction: actual addr=%h expected %h", r, evict_addr, a);
          end
        end
      end
    end
  end

  task automatic step();
    @(negedge clk);
    lkp_valid = 1'b0; ins_valid = 1'b0; inv_valid = 1'b0;
  endtask

  task automatic lookup(input logic [BLK_W-1:0] a, input logic e, input string r);
    exp_hit_q.push_back(e); exp_hit_r.push_back(r);
    lkp_valid = 1'b1; lkp_addr = a;
    step();
  endtask

  task automatic insert(input logic [BLK_W-1:0] a);
    ins_valid = 1'b1; ins_addr = a;
    step();
  endtask

  task automatic invalidate(input logic [BLK_W-1:0] a);
    inv_valid = 1'b1; inv_addr = a;
    step();
  endtask

  task automatic expect_evict(input logic [BLK_W-1:0] a, input string r);
    exp_ev_q.push_back(a); exp_ev_r.push_back(r);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (lkp_resp_valid !== 1'b0 || lkp_hit !== 1'b0 || evict_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset outputs: actual %0b%0b%0b expected 000",
               lkp_resp_valid, lkp_hit, evict_valid);
    end
    rst = 1'b0;
    lookup(blk_b(0), 1'b0, "R1");

    // Fill with a duplicate insert of the first block: no eviction may occur (R4, R8).
    insert(blk_b(0));
    insert(blk_b(0));
    for (int k = 1; k < 48; k++) insert(blk_b(k));

    // Victims follow the tree rules (R9).
    expect_evict(blk_b(0), "R9 first victim");
    insert(blk_n(0));
    expect_evict(blk_b(32), "R9 leaf-skip victim");
    insert(blk_n(1));
    lookup(blk_b(16), 1'b1, "R10 refresh");
    expect_evict(blk_b(40), "R10 victim after lookup touch");
    insert(blk_n(2));

    lookup(blk_n(0), 1'b1, "R3");
    lookup(blk_b(0), 1'b0, "R9 evicted");
    lookup(blk_b(32), 1'b0, "R9 evicted");
    lookup(blk_b(40), 1'b0, "R10 evicted");
    lookup(blk_b(16), 1'b1, "R10 kept");
    lookup(blk_n(2), 1'b1, "R3");
    lookup(blk_b(47), 1'b1, "R3");

    // Invalidate, reuse of the freed slot without eviction.
    invalidate(blk_b(5));
    lookup(blk_b(5), 1'b0, "R5");
    insert(blk_n(3));
    lookup(blk_n(3), 1'b1, "R8");
    invalidate(blk_n(60));
    lookup(blk_b(2), 1'b1, "R5 absent invalidate");
    lookup(blk_b(3), 1'b1, "R5 absent invalidate");

    // Same-cycle invalidate and lookup.
    exp_hit_q.push_back(1'b0); exp_hit_r.push_back("R6");
    lkp_valid = 1'b1; lkp_addr = blk_b(7);
    inv_valid = 1'b1; inv_addr = blk_b(7);
    step();
    lookup(blk_b(7), 1'b0, "R6 after");

    // Same-cycle invalidate and insert with a free slot.
    ins_valid = 1'b1; ins_addr = blk_n(10);
    inv_valid = 1'b1; inv_addr = blk_n(10);
    step();
    lookup(blk_n(10), 1'b0, "R7");
    insert(blk_n(11));
    lookup(blk_n(11), 1'b1, "R8 free slot");
    // Full again: a clashing insert must not evict.
    ins_valid = 1'b1; ins_addr = blk_n(12);
    inv_valid = 1'b1; inv_addr = blk_n(12);
    step();
    lookup(blk_n(12), 1'b0, "R7 full");

    repeat (4) @(negedge clk);
    checks++;
    if (exp_hit_q.size() != 0 || exp_ev_q.size() != 0) begin
      fails++;
      $display("FAIL R2/R9 pending responses: actual %0d/%0d expected 0/0",
               exp_hit_q.size(), exp_ev_q.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion (R2)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule